// File: doc/BRIEF.md
# Four-Wire Byte Control Port

This block is a slave-only, full-duplex serial control port. An external host owns the serial clock and the active-low select line, and it starts every exchange. While the select line is low, the port collects one byte from the data-in line, most significant bit first. At the same time it sends one response byte on the data-out line. When the select line goes high, the collected byte is passed to the core logic with a single-cycle valid strobe. The core may then load the next response byte through a ready/load handshake. That handshake is only open while the port is idle.

The whole block runs in the system clock domain. The serial clock, select and data-in inputs each pass through a synchronizer chain, and their edges are detected from the synchronized values. The system clock must be at least eight times faster than the serial clock. Data-out is given as a data bit plus an output enable, and a tristate buffer at the pad combines them.

Bursts that are not eight clocks long follow fixed rules:

- **Short burst.** The bits received are right-aligned, and zeros fill the bits above them.
- **Long burst.** Only the most recent eight bits are kept.
- **Past the last response bit.** Data-out repeats the data-in stream, delayed by eight serial clocks.

Top module: `byte_link_slave`

## Requirements
- R1: Data-in is sampled on each rising serial-clock edge while selected, and the bits are assembled most significant first. An 8-clock burst delivers exactly the eight bits sent, with the first bit sent at bit 7.
- R2: The response byte goes out most significant bit first. Bit 7 appears on data-out once the falling edge of select has been seen. Each following bit replaces the previous one after a falling serial-clock edge.
- R3: The output enable is 0 while select is high and 1 while select is low. Both levels apply once select has passed the synchronizer.
- R4: Each select release that follows a select assertion produces exactly one rxValid pulse, one system clock long. rxByte holds the collected byte during that pulse.
- R5: With fewer than 8 serial clocks in a burst, the received bits are right-aligned in rxByte and the unused upper bits read 0.
- R6: With more than 8 serial clocks in a burst, rxByte holds the last 8 bits received, with the newest bit at bit 0.
- R7: After the eighth response bit, data-out repeats the bit received on data-in eight serial clocks earlier. This continues for as long as select stays low.
- R8: txReady is 1 only while the port is idle. A txLoad pulse while txReady is 1 stores txByte as the next response byte. A txLoad pulse during a transfer is ignored, and the stored response byte is used again for the next transfer.
- R9: Serial-clock edges while select is high produce no rxValid pulse and leave the output enable at 0.
- R10: After reset, the output enable is 0, rxValid is 0, txReady is 1, and the stored response byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the host |
| selN | input | 1 | Active-low select from the host |
| dataIn | input | 1 | Serial data from the host |
| dataOut | output | 1 | Serial data to the host (valid when dataOutEn is 1) |
| dataOutEn | output | 1 | Output enable for the data-out pad |
| txByte | input | DATA_W | Next response byte from the core |
| txLoad | input | 1 | Load strobe for txByte |
| txReady | output | 1 | Response register can be loaded |
| rxByte | output | DATA_W | Byte received in the last transfer |
| rxValid | output | 1 | One-cycle strobe marking rxByte as new |

## Verification
The hardest case is the echo phase. It only shows once a burst runs past eight clocks. Data-out must then carry data-in from eight serial clocks earlier, which tests that the receive and transmit shifts stay aligned across the synchronizer delay. The bench sweeps burst lengths from one to twelve clocks, each with a different data pattern and response byte. It predicts every data-out bit before each rising serial-clock edge, and the byte delivered on each select release. A load attempted in the middle of a transfer, followed by a transfer with no new load, shows at the data-out port whether the stored response byte was changed.

// File: rtl/byte_link_pkg.sv
package byte_link_pkg;
  typedef struct packed {
    logic start;      // select seen falling
    logic finish;     // select seen rising after a start
    logic sampleBit;  // rising serial clock while selected
    logic shiftOut;   // falling serial clock while selected
    logic acceptTx;   // response byte load accepted
  } linkStrobes_t;
endpackage

// File: rtl/byte_link_sync.sv
module byte_link_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/byte_link_ctrl.sv
module byte_link_ctrl
  import byte_link_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sckS,
  input  logic         selS,
  input  logic         txLoad,
  output linkStrobes_t strobes,
  output logic         active,
  output logic         txReady
);
  logic sckPrev, selPrev;
  logic sckRise, sckFall, selFall, selRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      selPrev <= 1'b1;
      active  <= 1'b0;
    end else begin
      sckPrev <= sckS;
      selPrev <= selS;
      if (selFall)      active <= 1'b1;
      else if (selRise) active <= 1'b0;
    end
  end

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign selFall = ~selS & selPrev;
  assign selRise = selS & ~selPrev;

  assign txReady = selS & ~active;

  always_comb begin
    strobes.start     = selFall;
    strobes.finish    = selRise & active;
    strobes.sampleBit = sckRise & ~selS & active;
    strobes.shiftOut  = sckFall & ~selS & active;
    strobes.acceptTx  = txLoad & txReady;
  end
endmodule

// File: rtl/byte_link_dpath.sv
module byte_link_dpath
  import byte_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobes_t      strobes,
  input  logic              dinS,
  input  logic [DATA_W-1:0] txByte,
  output logic              dataOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);
  logic [DATA_W-1:0] rxShift, txShift, txHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      txHold  <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strobes.acceptTx) txHold <= txByte;

      if (strobes.start)          rxShift <= '0;
      else if (strobes.sampleBit) rxShift <= {rxShift[DATA_W-2:0], dinS};

      // Received bits enter the transmit shift at its bottom, so they
      // reappear on the output one byte later.
      if (strobes.start)         txShift <= txHold;
      else if (strobes.shiftOut) txShift <= {txShift[DATA_W-2:0], rxShift[0]};

      rxValid <= strobes.finish;
      if (strobes.finish) rxByte <= rxShift;
    end
  end

  assign dataOut = txShift[DATA_W-1];
endmodule

// File: rtl/byte_link_slave.sv
module byte_link_slave
  import byte_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              selN,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txLoad,
  output logic              txReady,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);
  localparam int PINS = 3;
  localparam logic [PINS-1:0] PIN_RST = 3'b010; // select idles high

  logic [PINS-1:0] pinSync;
  linkStrobes_t    strobes;
  logic            active;

  byte_link_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) syncU (
    .clk(clk), .rstN(rstN),
    .asyncIn({sckIn, selN, dataIn}),
    .syncOut(pinSync)
  );

  byte_link_ctrl ctrlU (
    .clk(clk), .rstN(rstN),
    .sckS(pinSync[2]), .selS(pinSync[1]),
    .txLoad(txLoad),
    .strobes(strobes), .active(active), .txReady(txReady)
  );

  byte_link_dpath #(.DATA_W(DATA_W)) dpathU (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .dinS(pinSync[0]),
    .txByte(txByte),
    .dataOut(dataOut), .rxByte(rxByte), .rxValid(rxValid)
  );

  assign dataOutEn = active;
endmodule

// File: rtl/byte_link_checker.sv
module byte_link_checker (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic dataOutEn,
  input logic rxValid,
  input logic txReady
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R4
  AST_RELEASE_DELIVERS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOutEn) |-> rxValid); // R4
  AST_DELIVER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !dataOutEn); // R3
  AST_ENABLE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOutEn) |-> !$past(selN, 3)); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !dataOutEn); // R8
endmodule

bind byte_link_slave byte_link_checker checkU (
  .clk(clk), .rstN(rstN), .selN(selN),
  .dataOutEn(dataOutEn), .rxValid(rxValid), .txReady(txReady)
);

// File: tb/byte_link_slave_test.sv
`timescale 1ns/1ps
module byte_link_slave_test;
  logic clk = 0, rstN = 0;
  logic sckIn = 0, selN = 1, dataIn = 0, txLoad = 0;
  logic [7:0] txByte = 0;
  logic dataOut, dataOutEn, txReady, rxValid;
  logic [7:0] rxByte;

  int checks = 0, fails = 0, validCount = 0;
  logic [7:0] lastRx = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  byte_link_slave uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .selN(selN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .txByte(txByte), .txLoad(txLoad),
    .txReady(txReady), .rxByte(rxByte), .rxValid(rxValid)
  );

  always @(negedge clk) if (rxValid) begin
    validCount++;
    lastRx = rxByte;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadTx(input logic [7:0] v);
    @(negedge clk);
    chk(txReady == 1'b1, "R8 ready when idle", txReady, 1);
    txByte = v; txLoad = 1;
    @(negedge clk);
    txLoad = 0;
  endtask

  // n clocks; bits[j] is the j-th bit sent; expTx is the response byte expected.
  // midLoad: attempt a load of junk halfway through the burst.
  task automatic xfer(input int n, input logic [15:0] bits, input logic [7:0] expTx,
                      input bit midLoad);
    logic [7:0] expRx = 0;
    int vc0 = validCount;
    logic expOut;
    selN = 0; #80;
    chk(dataOutEn == 1'b1, "R3 enable while selected", dataOutEn, 1);
    for (int j = 0; j < n; j++) begin
      dataIn = bits[j]; #40;
      expOut = (j < 8) ? expTx[7-j] : bits[j-8];
      if (j < 8) chk(dataOut == expOut, "R2 response bit", dataOut, expOut);
      else       chk(dataOut == expOut, "R7 echo bit", dataOut, expOut);
      sckIn = 1; #80;
      sckIn = 0;
      if (midLoad && j == n/2) begin
        @(negedge clk);
        chk(txReady == 1'b0, "R8 not ready in transfer", txReady, 0);
        txByte = 8'hFF ^ expTx; txLoad = 1;
        @(negedge clk);
        txLoad = 0; #20;
      end else #40;
      expRx = {expRx[6:0], bits[j]};
    end
    selN = 1; #100;
    chk(validCount == vc0 + 1, "R4 one strobe per release", validCount - vc0, 1);
    if (n < 8)      chk(lastRx == expRx, "R5 short burst", lastRx, expRx);
    else if (n > 8) chk(lastRx == expRx, "R6 long burst", lastRx, expRx);
    else            chk(lastRx == expRx, "R1 full byte", lastRx, expRx);
    chk(dataOutEn == 1'b0, "R3 released", dataOutEn, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx;
    logic [7:0] pat;
    logic [15:0] bits;
    int vc;
    #33 rstN = 1; #40;
    chk(dataOutEn == 1'b0, "R10 reset enable", dataOutEn, 0);
    chk(rxValid == 1'b0, "R10 reset strobe", rxValid, 0);
    chk(txReady == 1'b1, "R10 reset ready", txReady, 1);
    bits = 16'hA5C3;
    xfer(8, bits, 8'h00, 0); // R10: reset response byte is zero

    for (int n = 1; n <= 12; n++) begin
      tx  = 8'((n * 53 + 29) & 255);
      pat = 8'((n * 91 + 17) & 255);
      for (int j = 0; j < 16; j++) bits[j] = pat[j % 8] ^ (j >= 8);
      loadTx(tx);
      xfer(n, bits, tx, 0);
    end

    // R8: load during transfer ignored, stored byte reused
    loadTx(8'h3C);
    xfer(8, 16'h0F96, 8'h3C, 1);
    xfer(10, 16'h02D1, 8'h3C, 0);

    // R9: clock edges while deselected
    vc = validCount;
    for (int k = 0; k < 6; k++) begin
      dataIn = k[0]; sckIn = 1; #80; sckIn = 0; #80;
      chk(dataOutEn == 1'b0, "R9 enable stays low", dataOutEn, 0);
    end
    #60;
    chk(validCount == vc, "R9 no strobe", validCount - vc, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule